// File: doc/BRIEF.md
# Burst Column Address Generator

This block sequences the column addresses of a single read or write burst for a four-bank synchronous DRAM controller. A one-cycle start pulse captures a start column, a burst-length code, an ordering select and the access direction. One edge later the first column appears with a valid flag. On each following edge the next column of the burst appears, and the final beat also carries a last flag.

The block supports both wrap orderings: an incrementing wrap and an XOR-based wrap. It has a whole-row mode that cycles through every column until it is halted. It also has a mode in which reads burst but every write is a single beat. A stop input ends any burst early. A start that arrives while a burst is running replaces that burst at once, so column commands can follow each other on consecutive clocks.

Command encoding, data paths, read latency and refresh belong to other blocks. This block only produces addresses, and only inside the wrap window of the current burst.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and right after it, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: When `start_i` is 1 at an edge, on the next cycle `valid_o` is 1 and `col_o` equals the `start_col_i` sampled at that edge.
- R3: `len_code_i` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and the unused codes 4, 5 and 6 give 1 beat. `valid_o` stays high for exactly that many consecutive cycles, and `last_o` is high only on the final one.
- R4: With `order_i` = 0, beat j keeps the column bits above the wrap window unchanged. Its low log2(length) bits equal the start's low bits plus j, modulo the length.
- R5: With `order_i` = 1, beat j keeps the upper bits unchanged. Its low log2(length) bits equal the start's low bits XOR j.
- R6: Code 7 is a whole-row burst. It always uses incrementing order, whatever `order_i` says. Its column advances by one modulo 2^COL_W on every beat, `last_o` never rises, and the burst continues until it is stopped or replaced.
- R7: `stop_i` high at an edge with `start_i` low makes `valid_o` and `last_o` 0 on the next cycle. When no burst is running, `stop_i` has no visible effect.
- R8: A `start_i` at any edge, including one in the middle of a burst or on its final beat, abandons the old burst. It produces the new burst's first beat on the next cycle, with no idle cycle in between.
- R9: When `single_wr_i` = 1 and `is_write_i` = 1, the burst is one beat long whatever the length code is.
- R10: When `single_wr_i` = 1 and `is_write_i` = 0, or when `single_wr_i` = 0, the burst uses the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the inputs below |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code (see R3, R6) |
| order_i | input | 1 | 0 = incrementing wrap, 1 = XOR wrap |
| is_write_i | input | 1 | The access being started is a write |
| single_wr_i | input | 1 | Mode bit: writes are single beats |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat of a burst |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench builds the block with COL_W = 8 and the XOR ordering enabled. With these values the 256-column whole-row burst can be exercised: a start near the top of the row shows the wrap from column 255 to column 0 within a few beats. An 8-beat window inside an 8-bit column shows that the upper bits stay fixed under both orderings. Back-to-back starts, aborts and stops are mixed into one stream, so the scoreboard checks the timing between bursts as well as the addresses within each burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   // Burst length codes. Their values are part of the port contract.
   localparam logic [2:0] LEN_1    = 3'd0;
   localparam logic [2:0] LEN_2    = 3'd1;
   localparam logic [2:0] LEN_4    = 3'd2;
   localparam logic [2:0] LEN_8    = 3'd3;
   localparam logic [2:0] LEN_PAGE = 3'd7;

   typedef enum logic {
      ORD_INC = 1'b0,
      ORD_XOR = 1'b1
   } wrap_order_e;

   // Settings captured for the burst that is running.
   typedef struct packed {
      logic        whole_row;
      wrap_order_e order;
   } burst_cfg_t;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import bcg_pkg::*;
#(
   parameter int COL_W          = 8,
   parameter bit ALLOW_XOR_WRAP = 1'b1
) (
   input  logic [2:0]       len_code,
   input  logic             order_sel,
   input  logic             is_write,
   input  logic             single_wr,
   output logic [COL_W-1:0] wrap_mask,
   output burst_cfg_t       cfg
);

   logic             force_single;
   logic [COL_W-1:0] mask_raw;
   logic             page_raw;

   assign force_single = single_wr & is_write;

   always_comb begin
      page_raw = 1'b0;
      mask_raw = '0;
      unique case (len_code)
         LEN_2:    mask_raw = COL_W'(1);
         LEN_4:    mask_raw = COL_W'(3);
         LEN_8:    mask_raw = COL_W'(7);
         LEN_PAGE: begin
            mask_raw = '1;
            page_raw = 1'b1;
         end
         default:  mask_raw = '0;
      endcase
   end

   assign wrap_mask     = force_single ? '0 : mask_raw;
   assign cfg.whole_row = page_raw & ~force_single;

   generate
      if (ALLOW_XOR_WRAP) begin : g_xor_on
         // A whole-row burst always increments.
         assign cfg.order = (order_sel && !cfg.whole_row) ? ORD_XOR : ORD_INC;
      end else begin : g_xor_off
         assign cfg.order = ORD_INC;
      end
   endgenerate

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
   import bcg_pkg::*;
#(
   parameter int COL_W          = 8,
   parameter bit ALLOW_XOR_WRAP = 1'b1
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat_idx,
   input  logic [COL_W-1:0] wrap_mask,
   input  wrap_order_e      order,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] fixed_part;
   logic [COL_W-1:0] inc_part;

   assign fixed_part = base_col & ~wrap_mask;
   assign inc_part   = (base_col + beat_idx) & wrap_mask;

   generate
      if (ALLOW_XOR_WRAP) begin : g_both
         logic [COL_W-1:0] xor_part;
         assign xor_part = (base_col ^ beat_idx) & wrap_mask;
         assign col = fixed_part | ((order == ORD_XOR) ? xor_part : inc_part);
      end else begin : g_inc_only
         assign col = fixed_part | inc_part;
      end
   endgenerate

endmodule

// File: rtl/bcg_sequencer.sv
module bcg_sequencer
   import bcg_pkg::*;
#(
   parameter int COL_W          = 8,
   parameter bit ALLOW_XOR_WRAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] start_col,
   input  logic [COL_W-1:0] new_mask,
   input  burst_cfg_t       new_cfg,
   output logic [COL_W-1:0] col_q,
   output logic             valid_q,
   output logic             last_q
);

   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic [COL_W-1:0] idx_q;
   burst_cfg_t       cfg_q;

   logic [COL_W-1:0] sel_base;
   logic [COL_W-1:0] sel_idx;
   logic [COL_W-1:0] sel_mask;
   burst_cfg_t       sel_cfg;
   logic [COL_W-1:0] next_col;
   logic             next_last;
   logic             advance;

   // A start loads fresh settings; otherwise the running burst steps on.
   always_comb begin
      if (start) begin
         sel_base = start_col;
         sel_idx  = '0;
         sel_mask = new_mask;
         sel_cfg  = new_cfg;
      end else begin
         sel_base = base_q;
         sel_idx  = idx_q + COL_W'(1);
         sel_mask = mask_q;
         sel_cfg  = cfg_q;
      end
   end

   assign next_last = ~sel_cfg.whole_row & (sel_idx == sel_mask);
   assign advance   = valid_q & ~last_q & ~stop;

   bcg_addr_map #(
      .COL_W          (COL_W),
      .ALLOW_XOR_WRAP (ALLOW_XOR_WRAP)
   ) u_map (
      .base_col  (sel_base),
      .beat_idx  (sel_idx),
      .wrap_mask (sel_mask),
      .order     (sel_cfg.order),
      .col       (next_col)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         idx_q   <= '0;
         cfg_q   <= '0;
         col_q   <= '0;
         valid_q <= 1'b0;
         last_q  <= 1'b0;
      end else if (start) begin
         base_q  <= start_col;
         mask_q  <= new_mask;
         cfg_q   <= new_cfg;
         idx_q   <= '0;
         col_q   <= next_col;
         valid_q <= 1'b1;
         last_q  <= next_last;
      end else if (advance) begin
         idx_q   <= sel_idx;
         col_q   <= next_col;
         last_q  <= next_last;
      end else begin
         valid_q <= 1'b0;
         last_q  <= 1'b0;
      end
   end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W          = 8,
   parameter bit ALLOW_XOR_WRAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             order_i,
   input  logic             is_write_i,
   input  logic             single_wr_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);

   localparam int MAX_WIN_BITS = 3;
   localparam int MAX_COL_W    = 16;

   generate
      if (COL_W < MAX_WIN_BITS) begin : g_chk_narrow
         $error("burst_col_gen: COL_W must cover an 8-beat window");
      end
      if (COL_W > MAX_COL_W) begin : g_chk_wide
         $error("burst_col_gen: COL_W above supported range");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   burst_cfg_t       dec_cfg;

   bcg_len_decode #(
      .COL_W          (COL_W),
      .ALLOW_XOR_WRAP (ALLOW_XOR_WRAP)
   ) u_dec (
      .len_code  (len_code_i),
      .order_sel (order_i),
      .is_write  (is_write_i),
      .single_wr (single_wr_i),
      .wrap_mask (dec_mask),
      .cfg       (dec_cfg)
   );

   bcg_sequencer #(
      .COL_W          (COL_W),
      .ALLOW_XOR_WRAP (ALLOW_XOR_WRAP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .stop      (stop_i),
      .start_col (start_col_i),
      .new_mask  (dec_mask),
      .new_cfg   (dec_cfg),
      .col_q     (col_o),
      .valid_q   (valid_o),
      .last_q    (last_o)
   );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [2:0]       len_code_i,
   input logic             is_write_i,
   input logic             single_wr_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);

   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);  // R3

   AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));  // R2

   AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);  // R3

   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (!valid_o && !last_o));  // R7

   AST_KEEP_GOING: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !stop_i) |=> valid_o);  // R8

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && is_write_i && single_wr_i) |=> last_o);  // R9

   AST_ROW_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_code_i == 3'd7 && !(is_write_i && single_wr_i)) |=> !last_o);  // R6

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .len_code_i  (len_code_i),
   .is_write_i  (is_write_i),
   .single_wr_i (single_wr_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

   localparam int COL_W = 8;

   typedef struct {
      logic [COL_W-1:0] col;
      logic             last;
      string            tag;
   } beat_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       len_code_i = '0;
   logic             order_i = 1'b0;
   logic             is_write_i = 1'b0;
   logic             single_wr_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;

   int    checks = 0;
   int    failures = 0;
   beat_t exp_q[$];

   always #4 clk = ~clk;  // 125 MHz

   burst_col_gen #(.COL_W(COL_W), .ALLOW_XOR_WRAP(1'b1)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .len_code_i  (len_code_i),
      .order_i     (order_i),
      .is_write_i  (is_write_i),
      .single_wr_i (single_wr_i),
      .stop_i      (stop_i),
      .col_o       (col_o),
      .valid_o     (valid_o),
      .last_o      (last_o)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Monitor: every valid beat must match the head of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected beat col", int'(col_o), 0);
         end else begin
            beat_t e;
            e = exp_q.pop_front();
            check(col_o == e.col, e.tag, "col", int'(col_o), int'(e.col));
            check(last_o == e.last, e.tag, "last", int'(last_o), int'(e.last));
         end
      end
   end

   // Driver: called at a falling edge, returns at the falling edge on
   // which the last expected beat is visible (or after the stop took effect).
   task automatic burst(input logic [COL_W-1:0] col, input logic [2:0] code,
                        input logic ord, input logic wr, input logic sw,
                        input int cut, input bit use_stop, input string tag);
      int len;
      int n;
      bit row;
      logic [COL_W-1:0] mask;
      row = 1'b0;
      case (code)
         3'd1: len = 2;
         3'd2: len = 4;
         3'd3: len = 8;
         3'd7: begin len = 1 << COL_W; row = 1'b1; end
         default: len = 1;
      endcase
      if (wr && sw) begin
         len = 1;
         row = 1'b0;
      end
      mask = COL_W'(len - 1);
      n = (cut > 0 && cut < len) ? cut : len;
      for (int j = 0; j < n; j++) begin
         beat_t b;
         logic [COL_W-1:0] jj;
         jj = COL_W'(j);
         if (ord && !row)
            b.col = (col & ~mask) | ((col ^ jj) & mask);
         else
            b.col = (col & ~mask) | ((col + jj) & mask);
         b.last = !row && (j == len - 1);
         b.tag = tag;
         exp_q.push_back(b);
      end
      start_i = 1'b1;
      start_col_i = col;
      len_code_i = code;
      order_i = ord;
      is_write_i = wr;
      single_wr_i = sw;
      @(negedge clk);
      start_i = 1'b0;
      for (int j = 1; j < n; j++) @(negedge clk);
      if (use_stop) begin
         stop_i = 1'b1;
         @(negedge clk);
         stop_i = 1'b0;
         check(valid_o == 1'b0 && last_o == 1'b0, "R7", "valid after stop",
               int'(valid_o), 0);
      end
   endtask

   task automatic idle(input int cycles);
      for (int j = 0; j < cycles; j++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(valid_o == 1'b0 && last_o == 1'b0 && col_o == '0, "R1",
            "reset state", int'({valid_o, last_o, col_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid_o == 1'b0, "R1", "idle after reset", int'(valid_o), 0);

      burst(8'h35, 3'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R2");
      idle(2);
      burst(8'h35, 3'd1, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R4");
      idle(1);
      burst(8'h36, 3'd2, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R4");
      idle(1);
      burst(8'h5D, 3'd3, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R3");
      idle(1);
      burst(8'h5D, 3'd3, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R5");
      idle(1);
      burst(8'h02, 3'd2, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R5");
      idle(1);
      burst(8'hA7, 3'd5, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R3");
      idle(2);
      check(valid_o == 1'b0, "R3", "reserved code one beat", int'(valid_o), 0);

      // Whole-row burst across the top of the row, XOR request ignored.
      burst(8'hFC, 3'd7, 1'b1, 1'b0, 1'b0, 10, 1'b1, "R6");
      idle(1);

      // Stop while idle: nothing appears.
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check(valid_o == 1'b0 && last_o == 1'b0, "R7", "stop when idle",
            int'(valid_o), 0);
      idle(1);

      // Abort mid-burst by a new start, then back-to-back on a final beat.
      burst(8'h10, 3'd3, 1'b0, 1'b0, 1'b0, 3, 1'b0, "R8");
      burst(8'h41, 3'd1, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R8");
      burst(8'h43, 3'd2, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R8");
      idle(2);

      burst(8'h6B, 3'd3, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R9");
      idle(2);
      check(valid_o == 1'b0, "R9", "single write ended", int'(valid_o), 0);
      burst(8'h6B, 3'd3, 1'b0, 1'b0, 1'b1, 0, 1'b0, "R10");
      idle(1);
      burst(8'h21, 3'd2, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R10");
      idle(3);

      check(exp_q.size() == 0, "R3", "beats left in scoreboard",
            exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule